// File: doc/BRIEF.md
# Post-Transmit Carrier Blinding and Two-Phase Deferral

This block sits between the physical-layer carrier-sense input and the transmit scheduler of a half-duplex Ethernet MAC. When the station's own transmission has actually put carrier on the line, the returning carrier edge opens a blinding window. For a fixed number of bit-time ticks after that edge, raw carrier sense is hidden from the rest of the MAC. This window is the guard time in which a transceiver may send its own heartbeat pulse. If the transmission never produced carrier, no window opens.

In parallel the block times the interframe gap and raises a "medium idle, may transmit" flag. The gap can be split into two phases. During the first phase, any carrier that gets through the blinding gate sets the phase counter back to zero. A restart of this phase does not reopen the blinding window. During the second phase carrier is ignored, so a station that has committed to transmit keeps that commitment. A disable input turns the split off. With the split off, carrier at any point in the gap starts the whole gap again. All durations are counted in ticks of a bit-rate strobe. At 10 Mb/s, 40 ticks are 4.0 µs.

Top module: `csb_defer_top`

## Requirements
- R1: While `rst` is high and on the first edge after it, `crs_masked` and `defer_done` are 0.
- R2: Outside a blinding window, `crs_masked` equals the value `crs_raw` had one clock earlier.
- R3: A blinding window opens on the clock edge where `tx_active` is 0, `crs_raw` is 0 and carrier was seen during the last transmission. The window then lasts `BLIND_TICKS` ticks of `bit_tick`. While it is open, `crs_masked` stays 0 whatever `crs_raw` does.
- R4: A transmission during which `crs_raw` never went high opens no blinding window. Carrier right after it passes through, as in R2.
- R5: `defer_done` is 0 on the clock after any cycle with `tx_active` high, and a rise of `tx_active` closes any open blinding window.
- R6: Once the medium is idle, `defer_done` rises after `PART1_TICKS` ticks of phase one followed by `PART2_TICKS` ticks of phase two.
- R7: With `two_part_off` = 0, unmasked carrier during phase one sets phase one back to its start. The blinding window is not reopened, so carrier after it still passes through.
- R8: With `two_part_off` = 0, carrier during phase two has no effect on when `defer_done` rises.
- R9: With `two_part_off` = 1, unmasked carrier during phase two sends the gap back to the start of phase one.
- R10: Unmasked carrier while `defer_done` is 1 clears `defer_done` two clocks after it appears on `crs_raw`, and the gap is timed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| crs_raw | input | 1 | Carrier sense from the transceiver |
| tx_active | input | 1 | High while this station transmits |
| two_part_off | input | 1 | 1 disables the two-phase split of the gap |
| crs_masked | output | 1 | Carrier sense after the blinding gate, registered |
| defer_done | output | 1 | Interframe gap complete, transmission allowed |

## Verification
The bench builds the block with `BLIND_TICKS` = 8, `PART1_TICKS` = 12 and `PART2_TICKS` = 6, so phase one outlasts the blinding window by only a few ticks. With these values, a carrier burst can land at either end of each phase within a few dozen cycles. It can also land in phase one after blinding has ended, or in phase two. Directed runs pin down the exact cycle counts for restarts in each phase and for both settings of the split. Long random runs, with an irregular tick strobe, test the interaction of overlapping transmissions and carrier bursts.

// File: rtl/csb_pkg.sv
package csb_pkg;

  typedef enum logic [1:0] {
    DF_BUSY   = 2'd0,
    DF_PHASE1 = 2'd1,
    DF_PHASE2 = 2'd2,
    DF_DONE   = 2'd3
  } defer_state_t;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/csb_tick_counter.sv
module csb_tick_counter #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic expire
);
  import csb_pkg::*;

  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run & tick & ~clr & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr || expire) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/csb_blinder.sv
module csb_blinder #(
  parameter int BLIND_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic crs_raw,
  input  logic tx_active,
  output logic crs_gated
);

  logic armed;
  logic blind;
  logic blind_end;

  csb_tick_counter #(.LIMIT(BLIND_TICKS)) u_blind_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (bit_tick),
    .run    (blind),
    .clr    (~blind),
    .expire (blind_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      blind     <= 1'b0;
      crs_gated <= 1'b0;
    end else begin
      crs_gated <= crs_raw & ~blind;
      if (tx_active) begin
        armed <= armed | crs_raw;
        blind <= 1'b0;
      end else if (armed && !crs_raw) begin
        armed <= 1'b0;
        blind <= 1'b1;
      end else if (blind_end) begin
        blind <= 1'b0;
      end
    end
  end

  // R3: an open window keeps the gated carrier low on the next edge
  assert_blind_masks_R3: assert property (@(posedge clk) disable iff (rst)
    blind |=> !crs_gated);

  // R4: a window can only open after a transmission that saw carrier
  assert_no_arm_no_blind_R4: assert property (@(posedge clk) disable iff (rst)
    (!armed && !blind) |=> !blind);

  // R5: transmission closes the window
  assert_tx_closes_blind_R5: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !blind);

endmodule

// File: rtl/csb_deferral.sv
module csb_deferral #(
  parameter int PART1_TICKS = 60,
  parameter int PART2_TICKS = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic crs_gated,
  input  logic tx_active,
  input  logic two_part_off,
  output logic defer_done
);
  import csb_pkg::*;

  defer_state_t state, state_nx;
  logic [1:0] ph_run, ph_clr, ph_exp;

  assign ph_run[0] = (state == DF_PHASE1);
  assign ph_clr[0] = (state != DF_PHASE1) | crs_gated;
  assign ph_run[1] = (state == DF_PHASE2);
  assign ph_clr[1] = (state != DF_PHASE2);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_phase
      csb_tick_counter #(.LIMIT((g == 0) ? PART1_TICKS : PART2_TICKS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .run    (ph_run[g]),
        .clr    (ph_clr[g]),
        .expire (ph_exp[g])
      );
    end
  endgenerate

  always_comb begin
    state_nx = state;
    if (tx_active) begin
      state_nx = DF_BUSY;
    end else begin
      case (state)
        DF_BUSY:   if (!crs_gated) state_nx = DF_PHASE1;
        DF_PHASE1: if (ph_exp[0]) state_nx = DF_PHASE2;
        DF_PHASE2: begin
          if (two_part_off && crs_gated) state_nx = DF_PHASE1;
          else if (ph_exp[1])            state_nx = DF_DONE;
        end
        DF_DONE:   if (crs_gated) state_nx = DF_PHASE1;
        default:   state_nx = DF_BUSY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= DF_BUSY;
    else     state <= state_nx;
  end

  assign defer_done = (state == DF_DONE);

  // R5: transmission always withdraws permission on the next edge
  assert_tx_clears_done_R5: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !defer_done);

  // R6: permission is only granted at the end of phase two
  assert_done_from_p2_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(defer_done) |-> $past(state == DF_PHASE2));

  // R8: carrier in phase two with the split enabled does not restart the gap
  assert_p2_carrier_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == DF_PHASE2 && !two_part_off && crs_gated && !tx_active)
      |=> state != DF_PHASE1);

  // R9: carrier in phase two with the split disabled restarts the gap
  assert_p2_carrier_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    (state == DF_PHASE2 && two_part_off && crs_gated && !tx_active)
      |=> state == DF_PHASE1);

  // R10: carrier withdraws permission
  assert_done_carrier_R10: assert property (@(posedge clk) disable iff (rst)
    (defer_done && crs_gated && !tx_active) |=> !defer_done);

endmodule

// File: rtl/csb_defer_top.sv
module csb_defer_top #(
  parameter int BLIND_TICKS = 40,
  parameter int PART1_TICKS = 60,
  parameter int PART2_TICKS = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic crs_raw,
  input  logic tx_active,
  input  logic two_part_off,
  output logic crs_masked,
  output logic defer_done
);

  logic crs_gated;

  csb_blinder #(.BLIND_TICKS(BLIND_TICKS)) u_blinder (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .crs_raw   (crs_raw),
    .tx_active (tx_active),
    .crs_gated (crs_gated)
  );

  csb_deferral #(
    .PART1_TICKS (PART1_TICKS),
    .PART2_TICKS (PART2_TICKS)
  ) u_deferral (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .crs_gated    (crs_gated),
    .tx_active    (tx_active),
    .two_part_off (two_part_off),
    .defer_done   (defer_done)
  );

  assign crs_masked = crs_gated;

  // R1: outputs stay low on the first edge after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!crs_masked && !defer_done));

endmodule

// File: tb/test_csb_defer_top.sv
module test_csb_defer_top;
  localparam int CLK_PERIOD = 10;
  localparam int B  = 8;
  localparam int P1 = 12;
  localparam int P2 = 6;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b1;
  logic crs_raw = 1'b0;
  logic tx_active = 1'b0;
  logic two_part_off = 1'b0;
  logic crs_masked, defer_done;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csb_defer_top #(.BLIND_TICKS(B), .PART1_TICKS(P1), .PART2_TICKS(P2)) i_csb_defer_top (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .crs_raw(crs_raw),
    .tx_active(tx_active), .two_part_off(two_part_off),
    .crs_masked(crs_masked), .defer_done(defer_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // Reference model written from the requirements (integer bookkeeping)
  bit m_seen, m_blind, m_gate;
  int m_left;     // ticks of blinding still to run
  int m_phase;    // 0 busy, 1 phase one, 2 phase two, 3 done
  int m_elapsed;  // ticks spent in the current phase

  always @(posedge clk) begin
    if (rst) begin
      m_seen <= 0; m_blind <= 0; m_gate <= 0; m_left <= 0;
      m_phase <= 0; m_elapsed <= 0;
    end else begin
      m_gate <= crs_raw && !m_blind;
      if (tx_active) begin
        m_seen <= m_seen || crs_raw; m_blind <= 0;
      end else if (m_seen && !crs_raw) begin
        m_seen <= 0; m_blind <= 1; m_left <= B;
      end else if (m_blind && bit_tick) begin
        if (m_left == 1) m_blind <= 0;
        m_left <= m_left - 1;
      end
      if (tx_active) begin
        m_phase <= 0; m_elapsed <= 0;
      end else begin
        case (m_phase)
          0: begin m_elapsed <= 0; if (!m_gate) m_phase <= 1; end
          1: if (m_gate) m_elapsed <= 0;
             else if (bit_tick) begin
               if (m_elapsed + 1 == P1) begin m_phase <= 2; m_elapsed <= 0; end
               else m_elapsed <= m_elapsed + 1;
             end
          2: if (two_part_off && m_gate) begin m_phase <= 1; m_elapsed <= 0; end
             else if (bit_tick) begin
               if (m_elapsed + 1 == P2) begin m_phase <= 3; m_elapsed <= 0; end
               else m_elapsed <= m_elapsed + 1;
             end
          default: if (m_gate) begin m_phase <= 1; m_elapsed <= 0; end
        endcase
      end
    end
  end

  bit cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2/R3 crs_masked vs model", crs_masked, m_gate);
      chk("R6 defer_done vs model", defer_done, (m_phase == 3) ? 1 : 0);
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finish_up();
  end

  // Measures cycles until defer_done, with a one-cycle carrier pulse at cycle inj
  task automatic gap_run(input int inj, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == inj + 1) chk("R4 carrier passes after carrier-free transmission", crs_masked, 1);
      crs_raw = (n == inj);
      if (defer_done || n > 500) break;
    end
    crs_raw = 1'b0;
  endtask

  task automatic quiet_tx();
    tx_active = 1'b1; crs_raw = 1'b0;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
  endtask

  int n;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 crs_masked in reset", crs_masked, 0);
    chk("R1 defer_done in reset", defer_done, 0);
    rst = 1'b0;
    cmp_en = 1'b1;

    // R6: idle medium after reset
    n = 0;
    forever begin
      @(negedge clk); n++;
      if (n == 1) chk("R1 defer_done after reset edge", defer_done, 0);
      if (defer_done || n > 500) break;
    end
    chk("R6 cycles from reset to defer_done", n, P1 + P2 + 1);

    // R3: own transmission with carrier, then carrier held during the window
    tx_active = 1'b1; crs_raw = 1'b1;
    repeat (5) @(negedge clk);
    tx_active = 1'b0; crs_raw = 1'b0;
    @(negedge clk);
    crs_raw = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (crs_masked || n > 100) break;
      n++;
    end
    chk("R3 cycles of hidden carrier", n, B);

    // R7: carrier in phase one after blinding is not re-blinded
    crs_raw = 1'b0;
    repeat (2) @(negedge clk);
    crs_raw = 1'b1;
    @(negedge clk);
    chk("R7 carrier passes, window not reopened", crs_masked, 1);
    crs_raw = 1'b0;

    // R7: restart of phase one by a pulse inside it
    quiet_tx();
    gap_run(3, n);
    chk("R7 gap with pulse in phase one", n, P1 + P2 + 5);

    // R8: pulse in phase two ignored
    quiet_tx();
    gap_run(P1 + 3, n);
    chk("R8 gap with pulse in phase two, split on", n, P1 + P2 + 1);

    // R9: split off, pulse in phase two restarts the gap
    two_part_off = 1'b1;
    quiet_tx();
    gap_run(P1 + 3, n);
    chk("R9 gap with pulse in phase two, split off", n, 2 * P1 + P2 + 5);
    two_part_off = 1'b0;

    // R10: carrier while permitted
    crs_raw = 1'b1;
    @(negedge clk);
    chk("R10 defer_done one cycle after carrier", defer_done, 1);
    crs_raw = 1'b0;
    @(negedge clk);
    chk("R10 defer_done two cycles after carrier", defer_done, 0);
    repeat (P1 + P2 + 4) @(negedge clk);
    chk("R10 defer_done regained", defer_done, 1);

    // R5: transmission withdraws permission
    tx_active = 1'b1;
    @(negedge clk);
    chk("R5 defer_done after tx_active", defer_done, 0);
    tx_active = 1'b0;

    // Random traffic checked against the model every cycle
    begin
      int tx_left = 0;
      bit tx_crs = 1'b0;
      for (int cyc = 0; cyc < 30000; cyc++) begin
        @(negedge clk);
        bit_tick = ($urandom % 3) != 0;
        if ($urandom % 600 == 0) two_part_off = ~two_part_off;
        if (tx_left > 0) begin
          tx_left--;
          tx_active = (tx_left != 0);
          crs_raw = (tx_left != 0) && tx_crs;
        end else if ($urandom % 150 == 0) begin
          tx_left = 10 + ($urandom % 40);
          tx_crs = ($urandom % 4) != 0;
          tx_active = 1'b1;
          crs_raw = tx_crs;
        end else if ($urandom % 25 == 0) begin
          crs_raw = ~crs_raw;
        end
      end
    end
    tx_active = 1'b0; crs_raw = 1'b0;
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule